// File: doc/BRIEF.md
# Priority Interrupt Level Controller

This block holds a bank of prioritised interrupt levels (128 by default) and picks which one the processor should service next. Every level carries three independent bits: an enable, a pending request and an active (in-service) flag. Software steers these bits with interrupt-control commands that name a level and a 3-bit function code. Hardware sources raise requests with single-cycle pulses on a request vector. A branch-and-reset strobe ends the service routine that currently holds the highest priority.

The block offers one level at a time. That level has the lowest number among the levels that are enabled and requested and that are not shadowed by an active level of equal or higher priority. The offer is a valid/ready stream: `svc_valid` with `svc_level` and the level's vector address `svc_vector`. The consumer accepts the offer by raising `svc_ready` in a cycle where `svc_valid` is high. While `svc_ready` stays low, nothing is granted and no state changes because of the offer. The offer may still move to a different level, or be withdrawn, if commands or new requests change which level is eligible. The offered level and vector stay put as long as no command, request pulse or clear arrives.

Vector addresses are spaced four bytes apart from a base of F0h. This puts the sixteen I/O service levels, 14h to 23h, at 140h through 17Ch.

Top module: `pil_ctrl`

## Requirements
- R1: After reset every level is disabled, not requested and not active, and `svc_valid` is low.
- R2: A command with function 000 enables the named level, and function 001 disables it. The result is visible in the cycle after the command edge.
- R3: Function 010 sets the named level's request, 011 sets its active flag, and 100 clears its active flag.
- R4: Functions 101, 110 and 111 change no enable, request or active state.
- R5: A level is offered only when it is enabled and requested. Among the eligible levels, the lowest level number is offered.
- R6: An active level keeps itself and every higher-numbered level from being offered until its active flag clears.
- R7: When `svc_valid` and `svc_ready` are both high at an edge, that edge clears the offered level's request and sets its active flag. With `svc_ready` low, no grant occurs and, without other inputs, the offer is held.
- R8: A `clr_valid` pulse clears the active flag of the lowest-numbered active level only. It has no effect when no level is active.
- R9: A request made on a disabled level stays pending and is offered once the level is enabled.
- R10: `svc_vector` equals F0h + 4 × `svc_level`. Level 14h maps to 140h and level 23h maps to 17Ch.
- R11: Each bit of `hw_req` that is high at an edge sets the request of the level with that index. Any number of bits may be high in the same cycle.
- R12: When a set and a clear of the same bit land on the same edge, the set wins. A new request survives a grant of its own level, and a grant or activate survives a deactivate or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Interrupt-control command strobe |
| cmd_func | input | 3 | Command function code |
| cmd_level | input | 7 | Level named by the command |
| hw_req | input | 128 | Per-level request pulses |
| clr_valid | input | 1 | Branch-and-reset: clear top active level |
| svc_ready | input | 1 | Consumer accepts the offered level |
| svc_valid | output | 1 | A level is offered |
| svc_level | output | 7 | Offered level number |
| svc_vector | output | 12 | Vector address of the offered level |

## Verification
The following properties are checked by assertions on every cycle:
- an offered level is always enabled and requested;
- no active level sits at or above the offered level;
- a grant leaves the level active;
- a stalled, quiet offer holds;
- a disable command always takes effect;
- a branch-and-reset clears the top active level;
- a set beats a clear on the same bit.

The bench scenarios cover the behaviours that need a history of several commands:
- priority ordering between several pending levels;
- a request held across a disabled period;
- the no-effect function codes;
- the exact vector values at the edges of the I/O range;
- collisions of a grant with a new request or a deactivate.

// File: rtl/pil_pkg.sv
package pil_pkg;
  localparam logic [2:0] FN_ENABLE     = 3'b000;
  localparam logic [2:0] FN_DISABLE    = 3'b001;
  localparam logic [2:0] FN_REQUEST    = 3'b010;
  localparam logic [2:0] FN_ACTIVATE   = 3'b011;
  localparam logic [2:0] FN_DEACTIVATE = 3'b100;
endpackage

// File: rtl/pil_first_set.sv
module pil_first_set #(
  parameter int W  = 128,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign found = |vec;

  // R5: the chosen index is a set bit with nothing set below it
  always_comb begin
    if (found) begin
      a_r5_pick_is_set : assert (vec[idx]);
      a_r5_pick_is_lowest : assert ((vec & ((W'(1) << idx) - W'(1))) == '0);
    end
  end
endmodule

// File: rtl/pil_level_bank.sv
module pil_level_bank #(
  parameter int N = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_en,
  input  logic [N-1:0] clr_en,
  input  logic [N-1:0] set_req,
  input  logic [N-1:0] clr_req,
  input  logic [N-1:0] set_act,
  input  logic [N-1:0] clr_act,
  output logic [N-1:0] en,
  output logic [N-1:0] req,
  output logic [N-1:0] act
);
  for (genvar g = 0; g < N; g++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en[g]  <= 1'b0;
        req[g] <= 1'b0;
        act[g] <= 1'b0;
      end else begin
        if (set_en[g])       en[g] <= 1'b1;
        else if (clr_en[g])  en[g] <= 1'b0;
        if (set_req[g])      req[g] <= 1'b1;
        else if (clr_req[g]) req[g] <= 1'b0;
        if (set_act[g])      act[g] <= 1'b1;
        else if (clr_act[g]) act[g] <= 1'b0;
      end
    end

    // R12: a set on the same edge as a clear leaves the bit set
    a_r12_req_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
      set_req[g] |=> req[g]);
    a_r12_act_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
      set_act[g] |=> act[g]);
  end
endmodule

// File: rtl/pil_ctrl.sv
module pil_ctrl #(
  parameter int NUM_LEVELS = 128,
  parameter int VEC_W      = 12,
  parameter logic [VEC_W-1:0] VEC_BASE = 12'h0F0,
  localparam int LW = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [2:0]            cmd_func,
  input  logic [LW-1:0]         cmd_level,
  input  logic [NUM_LEVELS-1:0] hw_req,
  input  logic                  clr_valid,
  input  logic                  svc_ready,
  output logic                  svc_valid,
  output logic [LW-1:0]         svc_level,
  output logic [VEC_W-1:0]      svc_vector
);
  import pil_pkg::*;
  localparam int N = NUM_LEVELS;

  logic [N-1:0] level_en, level_req, level_act;
  logic [N-1:0] cmd_sel, grant_sel, top_act_sel;
  logic [N-1:0] set_en, clr_en, set_req, clr_req, set_act, clr_act;
  logic [N-1:0] blocked, eligible;
  logic         act_found, grant;
  logic [LW-1:0] act_idx;

  assign cmd_sel = N'(1) << cmd_level;

  // highest-priority active level
  pil_first_set #(.W(N)) i_act_pick (
    .vec(level_act), .found(act_found), .idx(act_idx));

  // an active level shadows itself and everything numbered above it
  always_comb begin
    logic run;
    run = 1'b0;
    for (int i = 0; i < N; i++) begin
      run = run | level_act[i];
      blocked[i] = run;
    end
  end

  assign eligible = level_en & level_req & ~blocked;

  pil_first_set #(.W(N)) i_svc_pick (
    .vec(eligible), .found(svc_valid), .idx(svc_level));

  assign svc_vector = VEC_BASE + (VEC_W'(svc_level) << 2);

  assign grant       = svc_valid && svc_ready;
  assign grant_sel   = grant ? (N'(1) << svc_level) : '0;
  assign top_act_sel = (clr_valid && act_found) ? (N'(1) << act_idx) : '0;

  assign set_en  = (cmd_valid && cmd_func == FN_ENABLE)     ? cmd_sel : '0;
  assign clr_en  = (cmd_valid && cmd_func == FN_DISABLE)    ? cmd_sel : '0;
  assign set_req = hw_req | ((cmd_valid && cmd_func == FN_REQUEST) ? cmd_sel : '0);
  assign clr_req = grant_sel;
  assign set_act = grant_sel | ((cmd_valid && cmd_func == FN_ACTIVATE) ? cmd_sel : '0);
  assign clr_act = top_act_sel |
                   ((cmd_valid && cmd_func == FN_DEACTIVATE) ? cmd_sel : '0);

  pil_level_bank #(.N(N)) i_bank (
    .clk(clk), .rst_n(rst_n),
    .set_en(set_en), .clr_en(clr_en),
    .set_req(set_req), .clr_req(clr_req),
    .set_act(set_act), .clr_act(clr_act),
    .en(level_en), .req(level_req), .act(level_act));

  // R5: an offered level is enabled and requested
  a_r5_offer_enabled_requested : assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> (level_en[svc_level] && level_req[svc_level]));

  // R6: no active level at or above the offered one
  a_r6_no_active_above : assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && act_found) |-> (act_idx > svc_level));

  // R7: a grant leaves the level active
  a_r7_grant_marks_active : assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && svc_ready) |=> level_act[$past(svc_level)]);

  // R7: a stalled offer with no other input holds
  a_r7_hold_when_stalled : assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && !svc_ready && !cmd_valid && !clr_valid && hw_req == '0)
      |=> (svc_valid && $stable(svc_level)));

  // R2: disable takes effect
  a_r2_disable_applies : assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_func == FN_DISABLE) |=> !level_en[$past(cmd_level)]);

  // R8: branch-and-reset clears the top active level
  a_r8_clear_top_active : assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && act_found &&
     !(cmd_valid && cmd_func == FN_ACTIVATE && cmd_level == act_idx))
      |=> !level_act[$past(act_idx)]);
endmodule

// File: tb/test_pil_ctrl.sv
`timescale 1ns/1ps
module test_pil_ctrl;
  localparam int N = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd_func = '0;
  logic [6:0]   cmd_level = '0;
  logic [N-1:0] hw_req = '0;
  logic         clr_valid = 1'b0;
  logic         svc_ready = 1'b0;
  logic         svc_valid;
  logic [6:0]   svc_level;
  logic [11:0]  svc_vector;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  pil_ctrl i_pil_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
    .cmd_level(cmd_level), .hw_req(hw_req), .clr_valid(clr_valid),
    .svc_ready(svc_ready), .svc_valid(svc_valid), .svc_level(svc_level),
    .svc_vector(svc_vector));

  // behavioural reference model
  logic [N-1:0] m_en, m_req, m_act;
  logic [N-1:0] n_en, n_req, n_act;
  int top_a, pick_c;

  function automatic int model_pick(logic [N-1:0] en, logic [N-1:0] rq, logic [N-1:0] ac);
    int a = N;
    int c = N;
    for (int i = 0; i < N; i++) if (ac[i] && a == N) a = i;
    for (int i = 0; i < N; i++) if (i < a && en[i] && rq[i] && c == N) c = i;
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = '0; m_req = '0; m_act = '0;
    end else begin
      top_a = N;
      for (int i = 0; i < N; i++) if (m_act[i] && top_a == N) top_a = i;
      pick_c = model_pick(m_en, m_req, m_act);
      n_en = m_en; n_req = m_req; n_act = m_act;
      // clears first, then sets (sets win)
      if (pick_c < N && svc_ready) n_req[pick_c] = 1'b0;
      if (clr_valid && top_a < N) n_act[top_a] = 1'b0;
      if (cmd_valid && cmd_func == 3'b100) n_act[cmd_level] = 1'b0;
      if (cmd_valid && cmd_func == 3'b001) n_en[cmd_level] = 1'b0;
      if (cmd_valid && cmd_func == 3'b000) n_en[cmd_level] = 1'b1;
      n_req = n_req | hw_req;
      if (cmd_valid && cmd_func == 3'b010) n_req[cmd_level] = 1'b1;
      if (pick_c < N && svc_ready) n_act[pick_c] = 1'b1;
      if (cmd_valid && cmd_func == 3'b011) n_act[cmd_level] = 1'b1;
      m_en = n_en; m_req = n_req; m_act = n_act;
    end
  end

  task automatic check_eq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int c;
    c = model_pick(m_en, m_req, m_act);
    check_eq(cur_tag, "svc_valid", int'(svc_valid), int'(c < N));
    if (c < N) begin
      check_eq(cur_tag, "svc_level", int'(svc_level), c);
      check_eq(cur_tag, "svc_vector", int'(svc_vector), 'hF0 + 4 * c);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    if (rst_n) compare();
  endtask

  task automatic do_cmd(logic [2:0] f, int lvl);
    cmd_valid = 1'b1; cmd_func = f; cmd_level = 7'(lvl);
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset();
    svc_ready = 1'b0; cmd_valid = 1'b0; clr_valid = 1'b0; hw_req = '0;
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    cur_tag = "R1";
    check_eq("R1", "svc_valid after reset", int'(svc_valid), 0);

    // R9/R2: request held while disabled, then enable, then disable
    cur_tag = "R9";
    do_cmd(3'b010, 5);
    check_eq("R9", "no offer while disabled", int'(svc_valid), 0);
    cur_tag = "R2";
    do_cmd(3'b000, 5);
    check_eq("R2", "offer after enable", int'(svc_valid), 1);
    check_eq("R9", "held request level", int'(svc_level), 5);
    do_cmd(3'b001, 5);
    check_eq("R2", "no offer after disable", int'(svc_valid), 0);

    // R4: codes 101..111 leave disabled level untouched
    cur_tag = "R4";
    for (int f = 5; f < 8; f++) begin
      do_cmd(3'(f), 5);
      check_eq("R4", "no-effect code on disabled level", int'(svc_valid), 0);
    end
    do_cmd(3'b000, 5);
    for (int f = 5; f < 8; f++) begin
      do_cmd(3'(f), 5);
      check_eq("R4", "no-effect code keeps offer", int'(svc_level), 5);
    end

    // R5 priority
    do_reset();
    cur_tag = "R5";
    do_cmd(3'b000, 3); do_cmd(3'b000, 9); do_cmd(3'b000, 40);
    do_cmd(3'b010, 40);
    check_eq("R5", "single pending", int'(svc_level), 40);
    do_cmd(3'b010, 9);
    check_eq("R5", "lower number wins", int'(svc_level), 9);
    do_cmd(3'b010, 3);
    check_eq("R5", "lowest number wins", int'(svc_level), 3);

    // R7 stall then grant
    cur_tag = "R7";
    repeat (3) tick();
    check_eq("R7", "offer held while stalled", int'(svc_level), 3);
    svc_ready = 1'b1;
    tick();
    svc_ready = 1'b0;
    check_eq("R6", "active level blocks lower priority", int'(svc_valid), 0);

    // R8 branch-and-reset
    cur_tag = "R8";
    clr_valid = 1'b1; tick(); clr_valid = 1'b0;
    check_eq("R8", "next level after clear", int'(svc_level), 9);
    clr_valid = 1'b1; tick(); clr_valid = 1'b0;
    check_eq("R8", "clear with none active no effect", int'(svc_level), 9);

    // R3/R6 activate and deactivate
    cur_tag = "R3";
    do_cmd(3'b011, 20);
    check_eq("R3", "higher priority still offered", int'(svc_level), 9);
    svc_ready = 1'b1; tick(); svc_ready = 1'b0;
    check_eq("R6", "level 40 blocked by active", int'(svc_valid), 0);
    do_cmd(3'b100, 9);
    check_eq("R6", "still blocked by level 20", int'(svc_valid), 0);
    do_cmd(3'b100, 20);
    check_eq("R3", "deactivate frees level 40", int'(svc_level), 40);

    // R8: only the top active level is cleared
    do_cmd(3'b011, 10); do_cmd(3'b011, 30);
    clr_valid = 1'b1; tick(); clr_valid = 1'b0;
    check_eq("R8", "lower active still blocks", int'(svc_valid), 0);
    clr_valid = 1'b1; tick(); clr_valid = 1'b0;
    check_eq("R8", "offer after second clear", int'(svc_level), 40);

    // R10 vector edges of I/O range
    do_reset();
    cur_tag = "R10";
    do_cmd(3'b000, 'h14); do_cmd(3'b000, 'h23);
    do_cmd(3'b010, 'h23);
    check_eq("R10", "vector of level 23h", int'(svc_vector), 'h17C);
    do_cmd(3'b010, 'h14);
    check_eq("R10", "vector of level 14h", int'(svc_vector), 'h140);

    // R11 multiple hardware request pulses
    do_reset();
    cur_tag = "R11";
    for (int i = 0; i < N; i++) do_cmd(3'b000, i);
    hw_req = '0; hw_req[100] = 1'b1; hw_req[60] = 1'b1; hw_req[127] = 1'b1;
    tick(); hw_req = '0;
    check_eq("R11", "lowest of pulsed levels", int'(svc_level), 60);
    svc_ready = 1'b1; tick(); svc_ready = 1'b0;
    clr_valid = 1'b1; tick(); clr_valid = 1'b0;
    check_eq("R11", "next pulsed level", int'(svc_level), 100);

    // R12 collisions
    do_reset();
    cur_tag = "R12";
    do_cmd(3'b000, 2); do_cmd(3'b010, 2);
    svc_ready = 1'b1;
    do_cmd(3'b010, 2);
    svc_ready = 1'b0;
    check_eq("R12", "granted level now active", int'(svc_valid), 0);
    clr_valid = 1'b1; tick(); clr_valid = 1'b0;
    check_eq("R12", "request survived grant", int'(svc_level), 2);
    svc_ready = 1'b1;
    do_cmd(3'b100, 2);
    svc_ready = 1'b0;
    check_eq("R12", "grant beats deactivate", int'(svc_valid), 0);
    clr_valid = 1'b1; tick(); clr_valid = 1'b0;
    check_eq("R12", "request consumed", int'(svc_valid), 0);

    // mixed stimulus compared against the model every cycle
    do_reset();
    cur_tag = "R5";
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom % 16);
      cmd_valid = (r < 6);
      cmd_func = 3'($urandom % 8);
      cmd_level = 7'($urandom % 24);
      hw_req = '0;
      if (r == 7) hw_req[$urandom % 24] = 1'b1;
      clr_valid = (r == 8);
      svc_ready = ($urandom % 3 == 0);
      tick();
    end
    cmd_valid = 1'b0; hw_req = '0; clr_valid = 1'b0; svc_ready = 1'b0;
    tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule